// File: doc/BRIEF.md
# Staircase Slope Compensation and Peak-Current PWM Trip

This block drives one switching period at a time for a digital peak-current-mode power stage. At every period start it raises the switch drive and loads the current-reference code, which feeds an external DAC, with the value from the voltage-loop compensator. After a programmable start delay, it lowers that code by a fixed-point step at a regular interval. The result is a falling staircase that stands in for the analog compensation ramp. An external comparator watches the sensed switch current against the DAC voltage. Its asynchronous trip output is synchronized, and it ends the on-time for the rest of the period.

All settings are captured only at the period boundary, so an update from the control loop never bends a staircase that is already running. The running code is held with fractional bits, so step sizes that are not whole codes still add up exactly over the period. Only the integer part reaches the DAC.

Top module: `stair_slope_pwm`

## Requirements
- R1: While `rst_n` is low, `pwm_out` is 0 and `dac_code` is 0. The first clock edge after reset is released starts a period.
- R2: A period lasts exactly the `cfg_period` cycles captured at its start (`cfg_period` ≥ 2). At each period start `pwm_out` becomes 1 and `dac_code` becomes `comp_code`.
- R3: Counting the cycles after the start edge as offset t, the first decrement takes effect at t = `cfg_latency` + `cfg_interval`. Each further decrement follows `cfg_interval` cycles later (`cfg_interval` ≥ 1).
- R4: `cfg_step` is unsigned fixed point with FRAC_W = 8 fraction bits. After k decrements, `dac_code` = floor((`comp_code`·256 − k·`cfg_step`)/256).
- R5: The code saturates at 0 and never wraps below it.
- R6: No more than `cfg_steps` decrements occur in one period. After the last one the code holds until the next period start, even without a trip.
- R7: A `cfg_step` of 0 holds `dac_code` at `comp_code` for the whole period.
- R8: A rising `trip_async` seen before edge n drives `pwm_out` to 0 after edge n+2. `pwm_out` stays 0 until the next period start, and the staircase continues.
- R9: A trip that arrives before the start delay has ended also ends the on-time. `pwm_out` stays low after `trip_async` returns to 0.
- R10: Changes to `cfg_period`, `cfg_interval`, `cfg_latency`, `cfg_step` or `cfg_steps` in the middle of a period do not affect that period.
- R11: Changes to `comp_code` in the middle of a period do not affect that period's `dac_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | CNT_W | Period length in cycles |
| cfg_interval | input | CNT_W | Cycles between decrements |
| cfg_latency | input | CNT_W | Extra start delay in cycles |
| cfg_step | input | CODE_W+FRAC_W | Decrement size, fixed point |
| cfg_steps | input | NSTEP_W | Maximum decrements per period |
| comp_code | input | CODE_W | Uncompensated reference from the compensator |
| trip_async | input | 1 | Comparator trip, asynchronous |
| dac_code | output | CODE_W | Current-reference code to the DAC |
| pwm_out | output | 1 | Power switch drive |

## Verification
The assertions rely on the inputs staying within range: `cfg_period` at least 2 and `cfg_interval` at least 1. Without that, the period counter and the step timer would wrap without warning. The stimulus draws periods of 20 to 120 cycles and intervals of 1 to 6 cycles. A trip pulse is two cycles long and starts no later than six cycles before the period ends, so the synchronized trip never spills into the next start. The assertions about when `pwm_out` rises and falls depend on that timing.

// File: rtl/stair_slope_pwm.sv
module stair_slope_pwm #(
  parameter int CODE_W  = 10,
  parameter int FRAC_W  = 8,
  parameter int CNT_W   = 16,
  parameter int NSTEP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CNT_W-1:0]         cfg_period,
  input  logic [CNT_W-1:0]         cfg_interval,
  input  logic [CNT_W-1:0]         cfg_latency,
  input  logic [CODE_W+FRAC_W-1:0] cfg_step,
  input  logic [NSTEP_W-1:0]       cfg_steps,
  input  logic [CODE_W-1:0]        comp_code,
  input  logic                     trip_async,
  output logic [CODE_W-1:0]        dac_code,
  output logic                     pwm_out
);
  localparam int ACC_W = CODE_W + FRAC_W;

  logic [CNT_W-1:0]   pcnt, per_q, ivl_q;
  logic [CNT_W:0]     dly;
  logic [ACC_W-1:0]   acc, step_q;
  logic [NSTEP_W-1:0] left;
  logic               trip_s1, trip_s2, pwm_q;

  wire start    = (pcnt == per_q - 1'b1);
  wire step_now = (dly == '0) && (left != '0);
  wire [ACC_W-1:0] acc_dec = (acc > step_q) ? acc - step_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trip_s1 <= 1'b0;
      trip_s2 <= 1'b0;
    end else begin
      trip_s1 <= trip_async;
      trip_s2 <= trip_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt   <= '0;
      per_q  <= CNT_W'(1);
      ivl_q  <= CNT_W'(1);
      dly    <= '0;
      acc    <= '0;
      step_q <= '0;
      left   <= '0;
      pwm_q  <= 1'b0;
    end else if (start) begin
      pcnt   <= '0;
      per_q  <= cfg_period;
      ivl_q  <= cfg_interval;
      step_q <= cfg_step;
      left   <= cfg_steps;
      dly    <= {1'b0, cfg_latency} + {1'b0, cfg_interval} - 1'b1;
      acc    <= {comp_code, {FRAC_W{1'b0}}};
      pwm_q  <= 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
      if (step_now) begin
        acc  <= acc_dec;
        left <= left - 1'b1;
        dly  <= {1'b0, ivl_q} - 1'b1;
      end else if (dly != '0) begin
        dly <= dly - 1'b1;
      end
      if (trip_s2) pwm_q <= 1'b0;
    end
  end

  assign dac_code = acc[ACC_W-1:FRAC_W];
  assign pwm_out  = pwm_q;
endmodule

// File: rtl/stair_slope_pwm_chk.sv
module stair_slope_pwm_chk #(
  parameter int CODE_W  = 10,
  parameter int FRAC_W  = 8,
  parameter int NSTEP_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     trip_s2,
  input logic [CODE_W+FRAC_W-1:0] step_q,
  input logic [NSTEP_W-1:0]       left,
  input logic [CODE_W-1:0]        dac_code,
  input logic                     pwm_out
);
  always @(negedge clk) begin
    if (!rst_n) assert_reset_idle_R1: assert (!pwm_out && dac_code == '0);
  end

  assert_rise_only_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> $past(start));

  assert_never_climbs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> dac_code <= $past(dac_code));

  assert_zero_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && dac_code == '0) |=> dac_code == '0);

  assert_count_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && left == '0) |=> $stable(dac_code));

  assert_flat_when_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && step_q == '0) |=> $stable(dac_code));

  assert_trip_ends_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_s2 && !start) |=> !pwm_out);

  assert_cfg_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(step_q));
endmodule

bind stair_slope_pwm stair_slope_pwm_chk #(
  .CODE_W(CODE_W), .FRAC_W(FRAC_W), .NSTEP_W(NSTEP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .trip_s2(trip_s2),
  .step_q(step_q), .left(left), .dac_code(dac_code), .pwm_out(pwm_out)
);

// File: tb/stair_slope_pwm_tb.sv
module stair_slope_pwm_tb;
  localparam int CLK_P   = 10;
  localparam int CODE_W  = 10;
  localparam int FRAC_W  = 8;
  localparam int CNT_W   = 16;
  localparam int NSTEP_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] cfg_period = 16'd50, cfg_interval = 16'd1, cfg_latency = 16'd0;
  logic [CODE_W+FRAC_W-1:0] cfg_step = '0;
  logic [NSTEP_W-1:0] cfg_steps = '0;
  logic [CODE_W-1:0] comp_code = '0;
  logic trip_async = 1'b0;
  logic [CODE_W-1:0] dac_code;
  logic pwm_out;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  stair_slope_pwm #(.CODE_W(CODE_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W), .NSTEP_W(NSTEP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_interval(cfg_interval),
    .cfg_latency(cfg_latency), .cfg_step(cfg_step), .cfg_steps(cfg_steps),
    .comp_code(comp_code), .trip_async(trip_async), .dac_code(dac_code), .pwm_out(pwm_out));

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic longint steps_done(longint cnt, longint lat, longint ivl, longint t);
    longint k;
    if (t < lat + ivl) return 0;
    k = (t - lat) / ivl;
    return (k > cnt) ? cnt : k;
  endfunction

  function automatic longint exp_code(longint comp, longint step, longint k);
    longint v;
    v = comp * (1 << FRAC_W) - k * step;
    if (v < 0) v = 0;
    return v >> FRAC_W;
  endfunction

  task automatic do_period(input int per, input int ivl, input int lat, input int step,
                           input int cnt, input int comp, input int ta, input string focus);
    cfg_period = per; cfg_interval = ivl; cfg_latency = lat;
    cfg_step = step; cfg_steps = cnt; comp_code = comp;
    @(posedge clk);
    for (int t = 0; t < per; t++) begin
      longint k, e;
      string tg, tp;
      @(negedge clk);
      k = steps_done(cnt, lat, ivl, t);
      e = exp_code(comp, step, k);
      if (focus != "") tg = focus;
      else if (t == 0) tg = "R2";
      else if (step == 0) tg = "R7";
      else if (comp * (1 << FRAC_W) <= k * step) tg = "R5";
      else if (cnt > 0 && k == cnt) tg = "R6";
      else if (k == 1) tg = "R3";
      else tg = "R4";
      check(tg, dac_code, e);
      if (ta < 0) tp = "R2"; else if (ta < lat) tp = "R9"; else tp = "R8";
      check(tp, pwm_out, (ta >= 0 && t >= ta + 3) ? 0 : 1);
      if (t == ta) trip_async = 1'b1;
      if (t == ta + 2) trip_async = 1'b0;
      if (t < per - 1) begin
        cfg_period = 16'($urandom_range(2, 300)); cfg_interval = 16'($urandom_range(1, 9));
        cfg_latency = 16'($urandom_range(0, 40)); cfg_step = 18'($urandom_range(0, 5000));
        cfg_steps = 8'($urandom_range(0, 255)); comp_code = 10'($urandom_range(0, 1023));
      end
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20251);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", dac_code, 0);
    check("R1", pwm_out, 0);
    rst_n = 1'b1;
    do_period(200, 2, 16, 624, 79, 700, -1, "");
    do_period(60, 1, 0, 768, 40, 5, -1, "");
    do_period(50, 3, 10, 0, 20, 512, 0, "");
    do_period(80, 2, 4, 300, 3, 900, 20, "");
    do_period(90, 1, 2, 1, 60, 1, -1, "");
    do_period(70, 4, 8, 100, 30, 1023, 40, "R10");
    do_period(70, 2, 0, 37, 25, 333, -1, "R11");
    for (int i = 0; i < 30; i++) begin
      int per, ta;
      per = $urandom_range(20, 120);
      ta  = ($urandom_range(0, 2) == 0) ? -1 : int'($urandom_range(0, per - 6));
      do_period(per, $urandom_range(1, 6), $urandom_range(0, 20),
                $urandom_range(0, 4095), $urandom_range(0, 40),
                $urandom_range(0, 1023), ta, "");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule